// File: doc/BRIEF.md
# Streaming Word Buffer with Flash-Style Parallel Host Port

This block lets a microcontroller's external static-memory controller treat an FPGA as if it were a 16-bit NAND-type flash part. The host does not present a full address. It first issues an address cycle that places an internal word pointer. It then streams reads or writes of consecutive 16-bit words, and the pointer steps forward by one after every data cycle. No handshake, interrupt or status poll is involved, so a DMA engine can move data with nothing else in the loop.

The host port has a shared bidirectional 16-bit data bus and five active controls: a chip select, a command-phase flag, an address-phase flag, a write strobe and a read strobe. The strobes are asynchronous to the FPGA clock. Each strobe passes through a multi-flop synchroniser followed by an edge detector. The data bus and the phase flags are delayed through a matching pipeline, so a write is taken from the bus value the host held while the strobe was still low. Behind the port sit a decoder that sorts the kinds of cycle, the wrapping pointer and a word buffer that is cleared at reset.

Top module: `nand_bus_slave`

## Requirements
- R1: After a synchronous active-low reset the pointer is 0 and every buffer location reads back as 16'h0000.
- R2: A write strobe rising edge while chip select is low, the address-phase flag is high and the command-phase flag is low loads the pointer from data bus bits [7:0] (with the default 256-word depth).
- R3: A write strobe rising edge while chip select is low and both phase flags are low stores the data bus word at the pointer, and the pointer then advances by one.
- R4: The block drives the data bus with the word at the pointer only while chip select and read strobe are both low. At all other times the bus is left free for another driver.
- R5: A read strobe rising edge while chip select is low and both phase flags are low advances the pointer by one, so successive reads return successive locations.
- R6: A write strobe edge with the command-phase flag high neither stores a word nor moves the pointer. The command flag takes priority over the address flag.
- R7: While chip select is high, write and read strobes have no effect on the buffer or the pointer.
- R8: The pointer wraps from the last location (255 by default) to 0 on a data cycle.
- R9: Two words written back to back, such as the two halves of a 32-bit value, are read back in the order they were written.
- R10: Write data is taken from the bus value present before the write strobe rises. A bus change at the same instant as the rising edge does not affect the stored word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | FPGA clock, at least four times the strobe rate |
| rst_n | input | 1 | Synchronous active-low reset |
| io_data | inout | 16 | Shared host data bus |
| cs_n | input | 1 | Chip select, active low |
| cmd_sel | input | 1 | Command-phase flag, active high |
| adr_sel | input | 1 | Address-phase flag, active high |
| wstb_n | input | 1 | Write strobe, active low, acted on at its rising edge |
| rstb_n | input | 1 | Read strobe, active low, bus driven while low |

## Verification
The case that is hardest to reach from the ports is a host that changes the data bus at the same instant it releases the write strobe. A design that samples on the wrong side of the synchroniser delay would then store the next word, which shows up as an off-by-one error. The bench has a write scenario that swaps the bus value at exactly the rising edge and then reads the location back. The wrap from the last word is reached by placing the pointer two words from the end with an address cycle, which avoids streaming through the whole buffer. Bus release is tested by driving the bus from the bench during a deselected read and reading back the bench's own value.

// File: rtl/nbs_pkg.sv
// Package: shared widths and types for the flash-style host port buffer.
// Assumes a fixed 16-bit host data bus.
package nbs_pkg;

    localparam int NBS_DATA_W = 16;

    // Snapshot of the host-side inputs, delayed to line up with a strobe edge.
    typedef struct packed {
        logic                  cs_n;
        logic                  cmd;
        logic                  adr;
        logic [NBS_DATA_W-1:0] data;
    } bus_snap_t;

    // Classification of a write-strobe rising edge.
    typedef enum logic [1:0] {
        WCYC_NONE = 2'd0,
        WCYC_CMD  = 2'd1,
        WCYC_ADDR = 2'd2,
        WCYC_DATA = 2'd3
    } wcyc_e;

endpackage

// File: rtl/nbs_strobe_sync.sv
// Module: nbs_strobe_sync
// Brings an asynchronous active-low strobe into the clock domain through
// STAGES flops and reports one-cycle pulses on its rising (release) edge.
// Assumes the strobe stays at each level for at least two clock periods.
module nbs_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic rise
);

    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // Shift the raw strobe through the synchroniser chain; idle level is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], strobe_n};
        end
    end

    // Remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b1;
        end else begin
            last_q <= chain_q[STAGES-1];
        end
    end

    assign rise = chain_q[STAGES-1] & ~last_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R5

endmodule

// File: rtl/nbs_bus_snap.sv
// Module: nbs_bus_snap
// Delays the host data bus and phase flags by STAGES+1 cycles so that, when
// a synchronised strobe edge is reported, the output holds the bus as it was
// one clock before the synchroniser first saw the strobe high.
// Assumes the host keeps data and flags stable while the strobe is low.
module nbs_bus_snap
    import nbs_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_n,
    input  logic                  cmd,
    input  logic                  adr,
    input  logic [NBS_DATA_W-1:0] data,
    output bus_snap_t             snap
);

    localparam int DEPTH = STAGES + 1;

    bus_snap_t pipe_q [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_stage
            if (g == 0) begin : g_head
                // First stage captures the live host inputs.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        pipe_q[0] <= '{cs_n: 1'b1, cmd: 1'b0, adr: 1'b0, data: '0};
                    end else begin
                        pipe_q[0] <= '{cs_n: cs_n, cmd: cmd, adr: adr, data: data};
                    end
                end
            end else begin : g_tail
                // Later stages simply delay the previous stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        pipe_q[g] <= '{cs_n: 1'b1, cmd: 1'b0, adr: 1'b0, data: '0};
                    end else begin
                        pipe_q[g] <= pipe_q[g-1];
                    end
                end
            end
        end
    endgenerate

    assign snap = pipe_q[DEPTH-1];

endmodule

// File: rtl/nbs_decode.sv
// Module: nbs_decode
// Turns synchronised strobe edges and the aligned bus snapshot into pointer
// load, pointer step, buffer write and command events.
// Assumes a deselected chip ignores everything; command outranks address.
module nbs_decode
    import nbs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              wr_rise,
    input  logic              rd_rise,
    input  bus_snap_t         snap,
    output logic              addr_ld,
    output logic [ADDR_W-1:0] addr_val,
    output logic              cmd_hit,
    output logic              wr_en,
    output logic              step
);

    wcyc_e wkind;
    logic  rd_data;

    // Sort a write edge into command, address or data cycle.
    always_comb begin
        if (!wr_rise || snap.cs_n) begin
            wkind = WCYC_NONE;
        end else if (snap.cmd) begin
            wkind = WCYC_CMD;
        end else if (snap.adr) begin
            wkind = WCYC_ADDR;
        end else begin
            wkind = WCYC_DATA;
        end
    end

    // A read edge counts only when selected and outside command/address phases.
    always_comb begin
        rd_data = rd_rise && !snap.cs_n && !snap.cmd && !snap.adr;
    end

    assign addr_ld  = (wkind == WCYC_ADDR);
    assign addr_val = snap.data[ADDR_W-1:0];
    assign cmd_hit  = (wkind == WCYC_CMD);
    assign wr_en    = (wkind == WCYC_DATA);
    assign step     = (wkind == WCYC_DATA) || rd_data;

endmodule

// File: rtl/nbs_pointer.sv
// Module: nbs_pointer
// Word pointer: loaded by address cycles, advanced by data cycles, wrapping
// from DEPTH-1 to 0. Assumes load and step never need to act together.
module nbs_pointer #(
    parameter int DEPTH  = 256,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_ld,
    input  logic [ADDR_W-1:0] addr_val,
    input  logic              step,
    input  logic              cmd_hit,
    output logic [ADDR_W-1:0] ptr
);

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    // Load, advance with wrap, or hold the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (addr_ld) begin
            ptr <= addr_val;
        end else if (step) begin
            ptr <= (ptr == LAST) ? '0 : ptr + ADDR_W'(1);
        end
    end

    AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ld |=> ptr == $past(addr_val)); // R2
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !addr_ld) |=> (ptr == '0) || ((ptr - $past(ptr)) == ADDR_W'(1))); // R3
    AST_CMD_HOLDS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_hit && !step) |=> $stable(ptr)); // R6

endmodule

// File: rtl/nbs_word_ram.sv
// Module: nbs_word_ram
// Word buffer with one synchronous write port and an asynchronous read port.
// Every location is cleared by reset so unwritten words read as zero.
module nbs_word_ram #(
    parameter int DEPTH  = 256,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Clear on reset, otherwise store the write word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem_q[$past(waddr)] == $past(wdata)); // R3

endmodule

// File: rtl/nand_bus_slave.sv
// Module: nand_bus_slave (top)
// Flash-style host port in front of a word buffer: address cycle sets the
// pointer, data cycles stream consecutive words. Assumes the clock runs at
// least four times the strobe rate and DEPTH fits in 16 address bits.
module nand_bus_slave
    import nbs_pkg::*;
#(
    parameter int DEPTH       = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    inout  wire  [15:0] io_data,
    input  logic        cs_n,
    input  logic        cmd_sel,
    input  logic        adr_sel,
    input  logic        wstb_n,
    input  logic        rstb_n
);

    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic                  wr_rise;
    logic                  rd_rise;
    bus_snap_t             snap;
    logic                  addr_ld;
    logic [ADDR_W-1:0]     addr_val;
    logic                  cmd_hit;
    logic                  wr_en;
    logic                  step;
    logic [ADDR_W-1:0]     ptr;
    logic [NBS_DATA_W-1:0] rd_word;
    logic                  bus_drive;

    nbs_strobe_sync #(.STAGES(SYNC_STAGES)) i_wr_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n (wstb_n),
        .rise     (wr_rise)
    );

    nbs_strobe_sync #(.STAGES(SYNC_STAGES)) i_rd_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n (rstb_n),
        .rise     (rd_rise)
    );

    nbs_bus_snap #(.STAGES(SYNC_STAGES)) i_snap (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .cmd   (cmd_sel),
        .adr   (adr_sel),
        .data  (io_data),
        .snap  (snap)
    );

    nbs_decode #(.ADDR_W(ADDR_W)) i_decode (
        .wr_rise  (wr_rise),
        .rd_rise  (rd_rise),
        .snap     (snap),
        .addr_ld  (addr_ld),
        .addr_val (addr_val),
        .cmd_hit  (cmd_hit),
        .wr_en    (wr_en),
        .step     (step)
    );

    nbs_pointer #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_pointer (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_ld  (addr_ld),
        .addr_val (addr_val),
        .step     (step),
        .cmd_hit  (cmd_hit),
        .ptr      (ptr)
    );

    nbs_word_ram #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(NBS_DATA_W)) i_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .waddr (ptr),
        .wdata (snap.data),
        .raddr (ptr),
        .rdata (rd_word)
    );

    // Drive the bus only during a selected read strobe.
    assign bus_drive = !cs_n && !rstb_n;
    assign io_data   = bus_drive ? rd_word : 16'hzzzz;

endmodule

// File: tb/test_nand_bus_slave.sv
module test_nand_bus_slave;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        cmd_sel = 1'b0;
    logic        adr_sel = 1'b0;
    logic        wstb_n = 1'b1;
    logic        rstb_n = 1'b1;
    logic        drv_en = 1'b0;
    logic [15:0] drv_val = 16'h0000;
    wire  [15:0] io_bus;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    assign io_bus = drv_en ? drv_val : 16'hzzzz;

    always #10 clk = ~clk;

    nand_bus_slave i_nand_bus_slave (
        .clk     (clk),
        .rst_n   (rst_n),
        .io_data (io_bus),
        .cs_n    (cs_n),
        .cmd_sel (cmd_sel),
        .adr_sel (adr_sel),
        .wstb_n  (wstb_n),
        .rstb_n  (rstb_n)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // kind: 0 data, 1 address, 2 command; sel_n is the chip select level.
    task automatic host_wr(input int kind, input logic [15:0] val, input logic sel_n);
        cs_n    = sel_n;
        adr_sel = (kind == 1);
        cmd_sel = (kind == 2);
        drv_val = val;
        drv_en  = 1'b1;
        wstb_n  = 1'b0;
        idle(3);
        wstb_n  = 1'b1;
        idle(2);
        drv_en  = 1'b0;
        adr_sel = 1'b0;
        cmd_sel = 1'b0;
        cs_n    = 1'b1;
        idle(4);
    endtask

    // Data write whose bus value changes at the very instant the strobe rises.
    task automatic host_wr_race(input logic [15:0] val, input logic [15:0] after);
        cs_n    = 1'b0;
        drv_val = val;
        drv_en  = 1'b1;
        wstb_n  = 1'b0;
        idle(3);
        wstb_n  = 1'b1;
        drv_val = after;
        idle(2);
        drv_en  = 1'b0;
        cs_n    = 1'b1;
        idle(4);
    endtask

    task automatic host_rd(input logic sel_n, output logic [15:0] v);
        cs_n   = sel_n;
        rstb_n = 1'b0;
        idle(3);
        v      = io_bus;
        rstb_n = 1'b1;
        idle(1);
        cs_n   = 1'b1;
        idle(4);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        host_rd(1'b0, v); check("R1 word0 after reset", v, 16'h0000);
        host_rd(1'b0, v); check("R1 word1 after reset", v, 16'h0000);
        host_wr(1, 16'h00C3, 1'b0);
        host_rd(1'b0, v); check("R1 untouched word", v, 16'h0000);
    endtask

    task automatic t_stream();
        logic [15:0] v;
        host_wr(1, 16'hAB10, 1'b0);           // only bits [7:0] = 0x10 used
        for (int i = 0; i < 4; i++) host_wr(0, 16'h1000 + 16'(i * 17), 1'b0);
        host_wr(1, 16'h0010, 1'b0);
        for (int i = 0; i < 4; i++) begin
            host_rd(1'b0, v);
            check("R2 R3 R5 stream readback", v, 16'h1000 + 16'(i * 17));
        end
        host_wr(1, 16'h0012, 1'b0);
        host_rd(1'b0, v); check("R2 address load mid-block", v, 16'h1022);
    endtask

    task automatic t_pair();
        logic [15:0] v;
        host_wr(1, 16'h0040, 1'b0);
        host_wr(0, 16'h5678, 1'b0);           // low half
        host_wr(0, 16'h1234, 1'b0);           // high half
        host_wr(1, 16'h0040, 1'b0);
        host_rd(1'b0, v); check("R9 first half", v, 16'h5678);
        host_rd(1'b0, v); check("R9 second half", v, 16'h1234);
    endtask

    task automatic t_cmd();
        logic [15:0] v;
        host_wr(1, 16'h0020, 1'b0);
        host_wr(0, 16'h1111, 1'b0);
        host_wr(2, 16'h00FF, 1'b0);           // command: no store, no move
        cmd_sel = 1'b1;
        host_wr(2, 16'h0077, 1'b0);           // priority over address is exercised below
        host_wr(0, 16'h2222, 1'b0);
        host_wr(1, 16'h0020, 1'b0);
        host_rd(1'b0, v); check("R6 word before command", v, 16'h1111);
        host_rd(1'b0, v); check("R6 pointer held by command", v, 16'h2222);
        host_rd(1'b0, v); check("R6 command stored nothing", v, 16'h0000);
        // Both flags high: must act as command, not load pointer to 0x40.
        host_wr(1, 16'h0020, 1'b0);
        cs_n = 1'b0; adr_sel = 1'b1; cmd_sel = 1'b1;
        drv_val = 16'h0040; drv_en = 1'b1; wstb_n = 1'b0;
        idle(3); wstb_n = 1'b1; idle(2);
        drv_en = 1'b0; adr_sel = 1'b0; cmd_sel = 1'b0; cs_n = 1'b1; idle(4);
        host_rd(1'b0, v); check("R6 command outranks address", v, 16'h1111);
    endtask

    task automatic t_select();
        logic [15:0] v;
        host_wr(1, 16'h0030, 1'b0);
        host_wr(0, 16'hAAAA, 1'b0);
        host_wr(0, 16'hBBBB, 1'b1);           // deselected write
        host_wr(1, 16'h0055, 1'b1);           // deselected address cycle
        host_wr(0, 16'hCCCC, 1'b0);
        host_wr(1, 16'h0030, 1'b0);
        host_rd(1'b1, v);                     // deselected read, must not step
        host_rd(1'b0, v); check("R7 first word kept", v, 16'hAAAA);
        host_rd(1'b0, v); check("R7 deselected write ignored", v, 16'hCCCC);
        // Bus released during a deselected read: bench value must survive.
        drv_val = 16'h5A5A; drv_en = 1'b1; cs_n = 1'b1; rstb_n = 1'b0;
        idle(2);
        check("R4 bus free while deselected", io_bus, 16'h5A5A);
        rstb_n = 1'b1; idle(1);
        check("R4 bus free while strobe high", io_bus, 16'h5A5A);
        drv_en = 1'b0; idle(4);
    endtask

    task automatic t_wrap();
        logic [15:0] v;
        host_wr(1, 16'h00FE, 1'b0);
        host_wr(0, 16'hE0FE, 1'b0);
        host_wr(0, 16'hE0FF, 1'b0);
        host_wr(0, 16'hE000, 1'b0);
        host_wr(1, 16'h00FE, 1'b0);
        host_rd(1'b0, v); check("R8 word 0xFE", v, 16'hE0FE);
        host_rd(1'b0, v); check("R8 word 0xFF", v, 16'hE0FF);
        host_rd(1'b0, v); check("R8 read wraps to 0", v, 16'hE000);
    endtask

    task automatic t_edge();
        logic [15:0] v;
        host_wr(1, 16'h0050, 1'b0);
        host_wr_race(16'h1357, 16'hDEAD);
        host_wr_race(16'h2468, 16'hBEEF);
        host_wr(1, 16'h0050, 1'b0);
        host_rd(1'b0, v); check("R10 data before edge", v, 16'h1357);
        host_rd(1'b0, v); check("R10 second word before edge", v, 16'h2468);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_stream();
        t_pair();
        t_cmd();
        t_select();
        t_wrap();
        t_edge();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule